// File: doc/BRIEF.md
# Byte-Wide Nonvolatile Store Access Controller

This block sits between a CPU's register bus and a 512-byte nonvolatile data store and lets software read or program one byte at a time. Software loads a 9-bit byte address split over two address registers, loads or reads a data register, and drives everything through a control register. Reads return the addressed byte into the data register after a fixed CPU stall. Writes are guarded by a two-step arming handshake: an arm bit is set alone, and the start bit must follow while the arm bit is still live. The arm bit expires by itself after a few cycles.

A started write latches its address and data, stalls the CPU briefly, and keeps its start bit set as a busy flag until the programming time, a cycle-count parameter, has elapsed. The byte is then committed to the store. While a flash self-programming operation is reported busy, no write may start. A level interrupt request tells software that the store is ready for the next write. The store is modelled as a register array that powers up to all ones and is not cleared by reset.

Top module: `nvb_access_ctrl`

## Requirements
- R1: After reset the control register reads 0x00, `cpu_stall` and `ready_irq` are 0, and every store byte reads 0xFF; reset never changes store contents.
- R2: Register select 0 holds address bits 7:0, select 1 holds address bit 8 in its bit 0 with its other bits reading 0, select 2 is the data register, and select 3 is the control register with bit 0 = read, bit 1 = write/busy, bit 2 = arm, bit 3 = ready-interrupt enable.
- R3: A control write with bit 2 = 1 and bit 1 = 0 sets the arm bit, which reads 1 for four cycles and then clears by itself.
- R4: A control write with bit 1 = 1 taken while the arm bit reads 1 starts a byte write of the current address and data registers; taken after the arm bit has cleared, it is ignored and the store is unchanged.
- R5: Control bit 1 reads 1 for exactly WR_CYCLES cycles (default 16) after a write starts, then clears, and the store byte holds the new value from then on.
- R6: While `flash_busy` is 1, a write request is not started even when armed.
- R7: A read request (control bit 0 = 1) raises `cpu_stall` for four cycles, bit 0 reads 1 during that time, and when the stall ends the data register holds the addressed byte and bit 0 reads 0.
- R8: A write start raises `cpu_stall` for two cycles.
- R9: A read request made while a write is in progress is ignored: no stall and the data register is unchanged.
- R10: `ready_irq` is 1 exactly when the ready-interrupt enable bit is 1 and no write is in progress.
- R11: Changing the address or data register during a write does not alter the byte being written or its location.
- R12: A control write with bits 2 and 1 both set while not armed neither arms nor starts a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select (0 addr low, 1 addr high, 2 data, 3 control) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read-back of the selected register |
| flash_busy | input | 1 | Flash self-programming in progress; blocks write starts |
| cpu_stall | output | 1 | CPU stall request for reads and write starts |
| ready_irq | output | 1 | Level ready interrupt request |

## Verification
The hardest situation to reach is the edge of the arming window, where one cycle decides whether a write starts. The stimulus arms, then idles a counted number of cycles before the start request, so one case lands on the final live cycle of the arm bit and the next lands one cycle later. The outcome is read through the busy bit, the stall length, and a read-back of the target byte. A second hard case puts register writes and a read request inside a running write, and afterwards checks both the old and the new address.

// File: rtl/nvb_pkg.sv
package nvb_pkg;

    // control register bit positions
    localparam int CTRL_W       = 4;
    localparam int CTRL_RD_BIT  = 0;
    localparam int CTRL_WR_BIT  = 1;
    localparam int CTRL_ARM_BIT = 2;
    localparam int CTRL_IE_BIT  = 3;

    typedef enum logic [1:0] {
        SEL_ADDR_LO = 2'd0,
        SEL_ADDR_HI = 2'd1,
        SEL_DATA    = 2'd2,
        SEL_CTRL    = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic ie;
        logic arm;
        logic wr;
        logic rd;
    } ctrl_req_t;

    function automatic ctrl_req_t decode_ctrl(input logic [CTRL_W-1:0] v);
        ctrl_req_t r;
        r.rd  = v[CTRL_RD_BIT];
        r.wr  = v[CTRL_WR_BIT];
        r.arm = v[CTRL_ARM_BIT];
        r.ie  = v[CTRL_IE_BIT];
        return r;
    endfunction

endpackage

// File: rtl/nvb_down_cnt.sv
module nvb_down_cnt #(
    parameter int LEN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic clr,
    output logic active,
    output logic last
);
    localparam int CW = $clog2(LEN + 1);
    localparam logic [CW-1:0] LOAD = CW'(LEN);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= LOAD;
        end else if (clr) begin
            cnt <= '0;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign active = (cnt != '0);
    assign last   = (cnt == CW'(1));
endmodule

// File: rtl/nvb_prog_engine.sv
module nvb_prog_engine #(
    parameter int AW        = 9,
    parameter int DW        = 8,
    parameter int WR_CYCLES = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_start,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    output logic          busy
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] store [DEPTH];
    logic [AW-1:0] job_addr;
    logic [DW-1:0] job_data;
    logic          done;

    // erased state of the array at power-up
    initial begin
        for (int i = 0; i < DEPTH; i++) store[i] = '1;
    end

    nvb_down_cnt #(.LEN(WR_CYCLES)) u_prog_tmr (
        .clk    (clk),
        .rst    (rst),
        .start  (wr_start),
        .clr    (1'b0),
        .active (busy),
        .last   (done)
    );

    // address and data are captured at start so later register writes
    // cannot disturb the job in flight
    always_ff @(posedge clk) begin
        if (rst) begin
            job_addr <= '0;
            job_data <= '0;
        end else if (wr_start) begin
            job_addr <= wr_addr;
            job_data <= wr_data;
        end
    end

    // contents are deliberately outside reset
    always_ff @(posedge clk) begin
        if (done) store[job_addr] <= job_data;
    end

    assign rd_data = store[rd_addr];
endmodule

// File: rtl/nvb_access_ctrl.sv
module nvb_access_ctrl
    import nvb_pkg::*;
#(
    parameter int AW        = 9,
    parameter int DW        = 8,
    parameter int ARM_WIN   = 4,
    parameter int RD_STALL  = 4,
    parameter int WR_STALL  = 2,
    parameter int WR_CYCLES = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_wr_en,
    input  logic [1:0]    reg_sel,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic          flash_busy,
    output logic          cpu_stall,
    output logic          ready_irq
);
    localparam int HI_W  = AW - DW;
    localparam int HI_PAD = DW - HI_W;
    localparam int CTRL_PAD = DW - CTRL_W;

    reg_sel_e  sel;
    ctrl_req_t req;
    logic      ctrl_wr;
    logic      arm_set, arm_live, arm_last;
    logic      wr_start, wr_busy;
    logic      rd_start, rd_active, rd_last;
    logic      ws_active, ws_last;
    logic      unused_lasts;

    logic [AW-1:0] addr_q;
    logic [DW-1:0] data_q;
    logic          ie_q;
    logic [DW-1:0] store_q;

    assign sel     = reg_sel_e'(reg_sel);
    assign req     = decode_ctrl(reg_wdata[CTRL_W-1:0]);
    assign ctrl_wr = reg_wr_en && (sel == SEL_CTRL);

    // arming: only a control write that leaves the start bit low
    assign arm_set  = ctrl_wr && req.arm && !req.wr;
    assign wr_start = ctrl_wr && req.wr && arm_live && !wr_busy
                      && !flash_busy && !rd_active;
    assign rd_start = ctrl_wr && req.rd && !wr_busy && !wr_start && !rd_active;

    nvb_down_cnt #(.LEN(ARM_WIN)) u_arm (
        .clk    (clk),
        .rst    (rst),
        .start  (arm_set),
        .clr    (wr_start),
        .active (arm_live),
        .last   (arm_last)
    );

    nvb_down_cnt #(.LEN(RD_STALL)) u_rd_stall (
        .clk    (clk),
        .rst    (rst),
        .start  (rd_start),
        .clr    (1'b0),
        .active (rd_active),
        .last   (rd_last)
    );

    nvb_down_cnt #(.LEN(WR_STALL)) u_wr_stall (
        .clk    (clk),
        .rst    (rst),
        .start  (wr_start),
        .clr    (1'b0),
        .active (ws_active),
        .last   (ws_last)
    );

    assign unused_lasts = arm_last | ws_last;

    nvb_prog_engine #(
        .AW        (AW),
        .DW        (DW),
        .WR_CYCLES (WR_CYCLES)
    ) u_engine (
        .clk      (clk),
        .rst      (rst),
        .wr_start (wr_start),
        .wr_addr  (addr_q),
        .wr_data  (data_q),
        .rd_addr  (addr_q),
        .rd_data  (store_q),
        .busy     (wr_busy)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            data_q <= '0;
            ie_q   <= 1'b0;
        end else begin
            if (reg_wr_en && sel == SEL_ADDR_LO) addr_q[DW-1:0]  <= reg_wdata;
            if (reg_wr_en && sel == SEL_ADDR_HI) addr_q[AW-1:DW] <= reg_wdata[HI_W-1:0];
            if (rd_last) begin
                data_q <= store_q;
            end else if (reg_wr_en && sel == SEL_DATA) begin
                data_q <= reg_wdata;
            end
            if (ctrl_wr) ie_q <= req.ie;
        end
    end

    always_comb begin
        unique case (sel)
            SEL_ADDR_LO: reg_rdata = addr_q[DW-1:0];
            SEL_ADDR_HI: reg_rdata = {{HI_PAD{1'b0}}, addr_q[AW-1:DW]};
            SEL_DATA:    reg_rdata = data_q;
            default:     reg_rdata = {{CTRL_PAD{1'b0}}, ie_q, arm_live, wr_busy, rd_active};
        endcase
    end

    assign cpu_stall = rd_active | ws_active;
    assign ready_irq = ie_q & ~wr_busy;
endmodule

// File: rtl/nvb_access_chk.sv
module nvb_access_chk #(
    parameter int ARM_WIN   = 4,
    parameter int WR_CYCLES = 16
) (
    input logic clk,
    input logic rst,
    input logic arm_set,
    input logic arm_live,
    input logic wr_busy,
    input logic rd_active,
    input logic cpu_stall,
    input logic flash_busy,
    input logic ready_irq
);
    logic [31:0] arm_run;
    logic [31:0] busy_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            arm_run  <= '0;
            busy_run <= '0;
        end else begin
            arm_run  <= arm_set ? 32'd1 : (arm_live ? arm_run + 32'd1 : 32'd0);
            busy_run <= wr_busy ? busy_run + 32'd1 : 32'd0;
        end
    end

    a_r3_arm_window: assert property (@(posedge clk) disable iff (rst)
        arm_live |-> (arm_run <= 32'(ARM_WIN)));

    a_r4_start_needs_arm: assert property (@(posedge clk) disable iff (rst)
        $rose(wr_busy) |-> $past(arm_live));

    a_r5_busy_length: assert property (@(posedge clk) disable iff (rst)
        $fell(wr_busy) |-> (busy_run == 32'(WR_CYCLES)));

    a_r6_flash_holdoff: assert property (@(posedge clk) disable iff (rst)
        $rose(wr_busy) |-> !$past(flash_busy));

    a_r7_read_stalls: assert property (@(posedge clk) disable iff (rst)
        rd_active |-> cpu_stall);

    a_r8_write_stalls: assert property (@(posedge clk) disable iff (rst)
        $rose(wr_busy) |-> cpu_stall);

    a_r9_no_read_in_write: assert property (@(posedge clk) disable iff (rst)
        wr_busy |-> !$rose(rd_active));

    a_r10_irq_quiet_busy: assert property (@(posedge clk) disable iff (rst)
        wr_busy |-> !ready_irq);
endmodule

bind nvb_access_ctrl nvb_access_chk #(
    .ARM_WIN   (ARM_WIN),
    .WR_CYCLES (WR_CYCLES)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .arm_set    (arm_set),
    .arm_live   (arm_live),
    .wr_busy    (wr_busy),
    .rd_active  (rd_active),
    .cpu_stall  (cpu_stall),
    .flash_busy (flash_busy),
    .ready_irq  (ready_irq)
);

// File: tb/sim_nvb_access_ctrl.sv
module sim_nvb_access_ctrl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_wr_en = 1'b0;
    logic [1:0] reg_sel = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       flash_busy = 1'b0;
    logic       cpu_stall;
    logic       ready_irq;

    int n_chk  = 0;
    int n_fail = 0;

    always #2500 clk = ~clk;   // 5 ns period in 1 ps steps

    nvb_access_ctrl u0 (
        .clk        (clk),
        .rst        (rst),
        .reg_wr_en  (reg_wr_en),
        .reg_sel    (reg_sel),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .flash_busy (flash_busy),
        .cpu_stall  (cpu_stall),
        .ready_irq  (ready_irq)
    );

    // ---------------- scoreboard ----------------
    typedef struct {
        string      tag;
        logic [1:0] sel;
        logic [7:0] exp;
    } exp_t;

    exp_t sb_q[$];
    event mon_ev;

    always @(mon_ev) begin
        exp_t e;
        e = sb_q.pop_front();
        n_chk++;
        if (reg_rdata !== e.exp) begin
            n_fail++;
            $display("FAIL %s: sel %0d got %h expected %h", e.tag, e.sel, reg_rdata, e.exp);
        end
    end

    task automatic expect_reg(input logic [1:0] s, input logic [7:0] v, input string tag);
        exp_t e;
        e.tag = tag; e.sel = s; e.exp = v;
        sb_q.push_back(e);
        reg_sel = s;
        #200;
        -> mon_ev;
        #100;
    endtask

    task automatic check_val(input int got, input int exp, input string tag);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    // ---------------- driver ----------------
    task automatic wr(input logic [1:0] s, input logic [7:0] v);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_sel = s; reg_wdata = v;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic set_addr(input logic [8:0] a);
        wr(2'd0, a[7:0]);
        wr(2'd1, {7'd0, a[8]});
    endtask

    task automatic do_read(input logic [8:0] a, output int stall_n);
        set_addr(a);
        wr(2'd3, 8'h01);
        stall_n = 0;
        while (cpu_stall) begin
            stall_n++;
            @(negedge clk);
        end
    endtask

    // arm, wait gap cycles, request the start; count busy and stall samples
    task automatic do_write(input logic [8:0] a, input logic [7:0] d, input int gap,
                            output int busy_n, output int stall_n);
        set_addr(a);
        wr(2'd2, d);
        wr(2'd3, 8'h04);
        repeat (gap) @(negedge clk);
        wr(2'd3, 8'h02);
        reg_sel = 2'd3;
        #200;
        busy_n = 0; stall_n = 0;
        while (reg_rdata[1]) begin
            busy_n++;
            if (cpu_stall) stall_n++;
            @(negedge clk);
        end
    endtask

    task automatic wait_idle();
        reg_sel = 2'd3;
        #200;
        while (reg_rdata[1]) @(negedge clk);
    endtask

    // ---------------- main sequence ----------------
    initial begin
        int sn, bn;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        expect_reg(2'd3, 8'h00, "R1 control after reset");
        check_val(cpu_stall, 0, "R1 stall after reset");
        check_val(ready_irq, 0, "R1 irq after reset");

        // R1 / R7 erased byte read with four-cycle stall
        do_read(9'h005, sn);
        check_val(sn, 4, "R7 read stall length");
        expect_reg(2'd2, 8'hFF, "R1 erased byte at 0x005");
        expect_reg(2'd3, 8'h00, "R7 read bit self-clears");

        // R2 register map
        wr(2'd0, 8'hA5);
        wr(2'd1, 8'hFF);
        expect_reg(2'd0, 8'hA5, "R2 address low");
        expect_reg(2'd1, 8'h01, "R2 address high keeps bit 0 only");

        // R4 / R5 / R8 write at top of window start
        do_write(9'h1A5, 8'h3C, 0, bn, sn);
        check_val(bn, 16, "R5 busy length");
        check_val(sn, 2, "R8 write stall length");
        do_read(9'h1A5, sn);
        expect_reg(2'd2, 8'h3C, "R5 byte committed at 0x1A5");

        // highest address
        do_write(9'h1FF, 8'h5A, 1, bn, sn);
        check_val(bn, 16, "R4 write to 0x1FF started");
        do_read(9'h1FF, sn);
        expect_reg(2'd2, 8'h5A, "R5 byte committed at 0x1FF");

        // R3 arm bit lifetime
        wr(2'd3, 8'h04);
        expect_reg(2'd3, 8'h04, "R3 arm set");
        repeat (3) @(negedge clk);
        expect_reg(2'd3, 8'h04, "R3 arm live on fourth cycle");
        @(negedge clk);
        expect_reg(2'd3, 8'h00, "R3 arm expired");

        // R4 last live cycle of the window
        do_write(9'h002, 8'h11, 2, bn, sn);
        check_val(bn, 16, "R4 start on final armed cycle");
        do_read(9'h002, sn);
        expect_reg(2'd2, 8'h11, "R4 byte at 0x002");

        // R4 one cycle too late
        do_write(9'h003, 8'h22, 3, bn, sn);
        check_val(bn, 0, "R4 late start ignored");
        check_val(cpu_stall, 0, "R4 late start no stall");
        do_read(9'h003, sn);
        expect_reg(2'd2, 8'hFF, "R4 byte at 0x003 untouched");

        // R12 both bits together, not armed
        wr(2'd3, 8'h06);
        expect_reg(2'd3, 8'h00, "R12 combined write neither arms nor starts");
        check_val(cpu_stall, 0, "R12 no stall");

        // R6 flash busy holds off the start
        set_addr(9'h004);
        wr(2'd2, 8'h44);
        wr(2'd3, 8'h04);
        flash_busy = 1'b1;
        wr(2'd3, 8'h02);
        expect_reg(2'd3, 8'h04, "R6 no start while flash busy");
        check_val(cpu_stall, 0, "R6 no stall while flash busy");
        flash_busy = 1'b0;
        repeat (20) @(negedge clk);
        do_read(9'h004, sn);
        expect_reg(2'd2, 8'hFF, "R6 byte at 0x004 untouched");

        // R10 / R9 / R11 interrupt, read during write, latched job
        set_addr(9'h100);
        wr(2'd2, 8'h77);
        wr(2'd3, 8'h0C);
        check_val(ready_irq, 1, "R10 irq while idle and enabled");
        wr(2'd3, 8'h0A);
        check_val(ready_irq, 0, "R10 irq low during write");
        wr(2'd0, 8'h01);
        wr(2'd2, 8'h99);
        wr(2'd3, 8'h09);
        check_val(cpu_stall, 0, "R9 read during write no stall");
        expect_reg(2'd3, 8'h0A, "R9 read bit not set during write");
        expect_reg(2'd2, 8'h99, "R9 data register unchanged");
        wait_idle();
        check_val(ready_irq, 1, "R10 irq back after write");
        do_read(9'h100, sn);
        expect_reg(2'd2, 8'h77, "R11 latched byte at 0x100");
        do_read(9'h101, sn);
        expect_reg(2'd2, 8'hFF, "R11 new address 0x101 untouched");
        check_val(ready_irq, 0, "R10 irq off after enable cleared");

        // R1 reset keeps contents
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        do_read(9'h100, sn);
        expect_reg(2'd2, 8'h77, "R1 contents survive reset");

        @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // watchdog
    initial begin
        #(64'd200000 * 64'd5000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule